// File: doc/BRIEF.md
# Page ECC status aggregator

This block condenses the error-correction outcome of one flash page into a single status register. A page is divided into four correction segments. Each covers 512 data bytes and the 16 spare bytes that belong with them, so a segment is 528 bytes and a page is 2112 bytes. As the decoder finishes each segment, it presents a 4-bit correction report with a strobe, and the block holds that report.

When the page read completes, the worst report among the segments is written to the low nibble of an 8-bit status register. The codes are: 0000 for clean, 0001 to 0100 for one to four corrected bits, and 1111 for uncorrectable. A reset command clears the register.

A host reads the register through a byte-wide serial command path. It selects the block, sends the readout command byte 7Ch, then sends one throwaway byte. After that, the block presents the register value as the response byte. It keeps presenting that value for as long as the select stays high.

Top module: `ecc_page_status_agg`

## Requirements
- R1: After `rst_n` is released, `status_reg` is 00h and `tx_valid` is 0.
- R2: On a cycle with `page_done` high and `reset_cmd` low, `status_reg` becomes, at that edge, the unsigned maximum of the held segment reports. Bits [7:4] are always 0.
- R3: If any held segment report is 1111 (uncorrectable), a page completion writes 0Fh, whatever the other segments hold.
- R4: `status_reg` keeps its value on every cycle where neither `page_done` nor `reset_cmd` is high.
- R5: `reset_cmd` clears `status_reg` to 00h at the next edge and takes priority over a `page_done` in the same cycle.
- R6: A segment's report is held when its bit of `seg_done` is high. Segment i uses `seg_code[4*i+3:4*i]`. All held reports return to 0000 on `page_done` or `reset_cmd`, and a `seg_done` in that same cycle is dropped.
- R7: With `cs` high, the command byte 7Ch is followed by one further byte of any value. From the edge that accepts that second byte, `tx_valid` is 1 and `tx_byte` equals `status_reg`, and this holds while `cs` stays high.
- R8: If the first byte after select is anything other than 7Ch, `tx_valid` stays 0 and `tx_byte` stays 00h until `cs` falls.
- R9: `cs` low returns the readout to idle at the next edge. A partly received sequence is dropped, and `tx_valid` is 0 after that edge.
- R10: While the response is being presented, `tx_byte` follows any later change of `status_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_done | input | 4 | Per-segment report strobe |
| seg_code | input | 16 | Packed per-segment correction codes, 4 bits each |
| page_done | input | 1 | Page read completion strobe |
| reset_cmd | input | 1 | Reset command strobe |
| cs | input | 1 | Serial command select, active high |
| rx_valid | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received command or dummy byte |
| status_reg | output | 8 | Page ECC status register |
| tx_valid | output | 1 | Response byte is being presented |
| tx_byte | output | 8 | Response byte, 00h when not valid |

## Verification
The reduction is exercised with random mixes of clean, correctable and uncorrectable segment codes. Some pages have every segment reporting and some have only a few, which separates a true maximum from a last-written or first-written value. Directed pages with one 1111 among low codes show that uncorrectable dominates. Completion, reset and segment strobes are placed in the same cycle to show that reset has priority and that the holding registers are cleared.

The readout path is driven with the correct command, a wrong command, and select dropped after the command alone. These runs show that the dummy byte is really skipped, that a foreign command stays silent, and that an abandoned sequence does not leave a stale response.

// File: rtl/page_ecc_pkg.sv
package page_ecc_pkg;
  localparam int CODE_W = 4;
  localparam int REG_W  = 8;
  localparam int BYTE_W = 8;

  localparam logic [CODE_W-1:0] CODE_CLEAN  = 4'b0000;
  localparam logic [CODE_W-1:0] CODE_UNCORR = 4'b1111;
  localparam logic [BYTE_W-1:0] CMD_RD_ECC  = 8'h7C;

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_DUMMY = 2'd1,
    RD_SEND  = 2'd2,
    RD_SKIP  = 2'd3
  } rd_state_t;

  // Unsigned maximum; 1111 is the largest code, so uncorrectable dominates.
  function automatic code_t worse_code(input code_t a, input code_t b);
    return (a > b) ? a : b;
  endfunction

  // Widen a 4-bit code into the register image with reserved bits zero.
  function automatic logic [REG_W-1:0] code_to_reg(input code_t c);
    return {{(REG_W-CODE_W){1'b0}}, c};
  endfunction
endpackage

// File: rtl/seg_report_hold.sv
module seg_report_hold
  import page_ecc_pkg::*;
#(
  parameter int N_SEG = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SEG-1:0]         seg_done,
  input  logic [N_SEG*CODE_W-1:0]  seg_code,
  input  logic                     clear,
  output logic [N_SEG*CODE_W-1:0]  held_codes,
  output logic                     any_uncorr
);
  logic [N_SEG-1:0] uncorr_bits;

  for (genvar g = 0; g < N_SEG; g++) begin : g_seg
    code_t held_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        held_q <= CODE_CLEAN;
      else if (clear)
        held_q <= CODE_CLEAN;
      else if (seg_done[g])
        held_q <= seg_code[g*CODE_W +: CODE_W];
    end
    assign held_codes[g*CODE_W +: CODE_W] = held_q;
    assign uncorr_bits[g] = (held_q == CODE_UNCORR);
  end

  assign any_uncorr = |uncorr_bits;
endmodule

// File: rtl/seg_worst_reduce.sv
module seg_worst_reduce
  import page_ecc_pkg::*;
#(
  parameter int N_SEG = 4
) (
  input  logic [N_SEG*CODE_W-1:0] held_codes,
  output code_t                   worst
);
  function automatic code_t reduce_all(input logic [N_SEG*CODE_W-1:0] v);
    code_t acc;
    acc = CODE_CLEAN;
    for (int i = 0; i < N_SEG; i++)
      acc = worse_code(acc, v[i*CODE_W +: CODE_W]);
    return acc;
  endfunction

  assign worst = reduce_all(held_codes);
endmodule

// File: rtl/ecc_status_store.sv
module ecc_status_store
  import page_ecc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reset_cmd,
  input  logic             page_done,
  input  code_t            worst,
  output logic [REG_W-1:0] status_q,
  output logic             upd_fire
);
  assign upd_fire = page_done && !reset_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      status_q <= '0;
    else if (reset_cmd)
      status_q <= '0;
    else if (upd_fire)
      status_q <= code_to_reg(worst);
  end
endmodule

// File: rtl/ecc_status_readout.sv
module ecc_status_readout
  import page_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [REG_W-1:0]  status_q,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              rd_skipping
);
  rd_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!cs) begin
      state_d = RD_IDLE;
    end else if (rx_valid) begin
      case (state_q)
        RD_IDLE:  state_d = (rx_byte == CMD_RD_ECC) ? RD_DUMMY : RD_SKIP;
        RD_DUMMY: state_d = RD_SEND;
        RD_SEND:  state_d = RD_SEND;
        RD_SKIP:  state_d = RD_SKIP;
        default:  state_d = RD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RD_IDLE;
    else        state_q <= state_d;
  end

  assign tx_valid    = (state_q == RD_SEND);
  assign tx_byte     = tx_valid ? status_q : '0;
  assign rd_skipping = (state_q == RD_SKIP);
endmodule

// File: rtl/ecc_page_status_agg.sv
module ecc_page_status_agg
  import page_ecc_pkg::*;
#(
  parameter int N_SEG = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_SEG-1:0]        seg_done,
  input  logic [N_SEG*CODE_W-1:0] seg_code,
  input  logic                    page_done,
  input  logic                    reset_cmd,
  input  logic                    cs,
  input  logic                    rx_valid,
  input  logic [BYTE_W-1:0]       rx_byte,
  output logic [REG_W-1:0]        status_reg,
  output logic                    tx_valid,
  output logic [BYTE_W-1:0]       tx_byte
);
  logic [N_SEG*CODE_W-1:0] held_codes;
  logic                    seg_uncorr_any;
  code_t                   worst_code;
  logic                    upd_fire;
  logic                    rd_skipping;
  logic                    hold_clear;

  assign hold_clear = page_done || reset_cmd;

  seg_report_hold #(.N_SEG(N_SEG)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .seg_done   (seg_done),
    .seg_code   (seg_code),
    .clear      (hold_clear),
    .held_codes (held_codes),
    .any_uncorr (seg_uncorr_any)
  );

  seg_worst_reduce #(.N_SEG(N_SEG)) u_reduce (
    .held_codes (held_codes),
    .worst      (worst_code)
  );

  ecc_status_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .reset_cmd (reset_cmd),
    .page_done (page_done),
    .worst     (worst_code),
    .status_q  (status_reg),
    .upd_fire  (upd_fire)
  );

  ecc_status_readout u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs          (cs),
    .rx_valid    (rx_valid),
    .rx_byte     (rx_byte),
    .status_q    (status_reg),
    .tx_valid    (tx_valid),
    .tx_byte     (tx_byte),
    .rd_skipping (rd_skipping)
  );
endmodule

// File: rtl/ecc_page_status_chk.sv
module ecc_page_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       page_done,
  input logic       reset_cmd,
  input logic       cs,
  input logic [7:0] status_reg,
  input logic       tx_valid,
  input logic [7:0] tx_byte,
  input logic       seg_uncorr_any,
  input logic       upd_fire,
  input logic       rd_skipping
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_reg[7:4] == 4'h0);

  assert_uncorr_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && seg_uncorr_any) |=> status_reg == 8'h0F);

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_done && !reset_cmd) |=> $stable(status_reg));

  assert_reset_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_cmd |=> status_reg == 8'h00);

  assert_tx_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_byte == status_reg);

  assert_skip_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_skipping |-> (!tx_valid && tx_byte == 8'h00));

  assert_cs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !tx_valid);
endmodule

bind ecc_page_status_agg ecc_page_status_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .page_done      (page_done),
  .reset_cmd      (reset_cmd),
  .cs             (cs),
  .status_reg     (status_reg),
  .tx_valid       (tx_valid),
  .tx_byte        (tx_byte),
  .seg_uncorr_any (seg_uncorr_any),
  .upd_fire       (upd_fire),
  .rd_skipping    (rd_skipping)
);

// File: tb/ecc_page_status_agg_tb.sv
module ecc_page_status_agg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  seg_done = '0;
  logic [15:0] seg_code = '0;
  logic        page_done = 0, reset_cmd = 0, cs = 0, rx_valid = 0;
  logic [7:0]  rx_byte = '0;
  logic [7:0]  status_reg, tx_byte;
  logic        tx_valid;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  // bench model
  logic [3:0] m_hold [4];
  logic [7:0] m_status;
  int         m_state; // 0 idle,1 after cmd,2 sending,3 skipping

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_page_status_agg u_dut (.*);

  function automatic logic [3:0] pick_code(int r);
    case (r % 6)
      0: return 4'h0; 1: return 4'h1; 2: return 4'h2;
      3: return 4'h3; 4: return 4'h4; default: return 4'hF;
    endcase
  endfunction

  function automatic logic [3:0] page_max();
    logic [3:0] m = 0;
    for (int i = 0; i < 4; i++) if (m_hold[i] > m) m = m_hold[i];
    return m;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // advance one clock with the inputs already driven, update model, compare
  task automatic step(string req);
    @(posedge clk);
    if (reset_cmd) m_status = 8'h00;
    else if (page_done) m_status = {4'h0, page_max()};
    for (int i = 0; i < 4; i++) begin
      if (reset_cmd || page_done) m_hold[i] = 4'h0;
      else if (seg_done[i]) m_hold[i] = seg_code[4*i +: 4];
    end
    if (!cs) m_state = 0;
    else if (rx_valid) begin
      case (m_state)
        0: m_state = (rx_byte == 8'h7C) ? 1 : 3;
        1: m_state = 2;
        default: ;
      endcase
    end
    @(negedge clk);
    check({req, "/R2 R4 R5 status"}, status_reg, m_status);
    check({req, "/R7 R8 R9 tx_valid"}, {7'd0, tx_valid}, {7'd0, m_state == 2});
    check({req, "/R7 R10 tx_byte"}, tx_byte, (m_state == 2) ? m_status : 8'h00);
    seg_done = '0; page_done = 0; reset_cmd = 0; rx_valid = 0;
  endtask

  task automatic send_byte(logic [7:0] b, string req);
    rx_valid = 1; rx_byte = b; step(req);
  endtask

  task automatic load_page(logic [3:0] c0, logic [3:0] c1, logic [3:0] c2, logic [3:0] c3, string req);
    seg_done = 4'hF; seg_code = {c3, c2, c1, c0}; step(req);
    page_done = 1; step(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++; vectors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 4; i++) m_hold[i] = 0;
    m_status = 0; m_state = 0;
    repeat (3) @(negedge clk);
    check("R1 status after reset", status_reg, 8'h00);
    check("R1 tx_valid after reset", {7'd0, tx_valid}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // R2 example: 1,0,2,0 -> 2
    load_page(4'h1, 4'h0, 4'h2, 4'h0, "R2 worst-of-four");
    check("R2 explicit 02h", status_reg, 8'h02);
    // R3 uncorrectable dominates
    load_page(4'h4, 4'hF, 4'h1, 4'h0, "R3 uncorr");
    check("R3 explicit 0Fh", status_reg, 8'h0F);
    // R6 holds cleared: only segment 2 reports next page
    seg_done = 4'b0100; seg_code = 16'h0300; step("R6 partial");
    page_done = 1; step("R6 partial");
    check("R6 stale holds cleared", status_reg, 8'h03);
    // R5 reset beats page_done
    seg_done = 4'hF; seg_code = 16'h4444; step("R5 setup");
    page_done = 1; reset_cmd = 1; step("R5 priority");
    check("R5 explicit 00h", status_reg, 8'h00);
    // R4 idle cycles
    load_page(4'h3, 4'h0, 4'h0, 4'h0, "R4 setup");
    repeat (5) step("R4 hold");

    // R7 readout
    cs = 1; step("R7 select");
    send_byte(8'h7C, "R7 cmd");
    check("R7 no response before dummy", {7'd0, tx_valid}, 8'h00);
    send_byte(8'hA5, "R7 dummy");
    check("R7 response byte", tx_byte, 8'h03);
    // R10 live tracking
    load_page(4'h0, 4'h1, 4'h0, 4'h0, "R10 live");
    check("R10 follows update", tx_byte, 8'h01);
    cs = 0; step("R9 deselect");
    // R8 wrong command
    cs = 1; send_byte(8'h0F, "R8 foreign");
    send_byte(8'h7C, "R8 foreign");
    send_byte(8'h00, "R8 foreign");
    check("R8 silent", {7'd0, tx_valid}, 8'h00);
    cs = 0; step("R9 deselect");
    // R9 abandon after command
    cs = 1; send_byte(8'h7C, "R9 partial");
    cs = 0; step("R9 drop");
    cs = 1; send_byte(8'h11, "R9 restart");
    check("R9 no stale response", {7'd0, tx_valid}, 8'h00);
    cs = 0; step("R9 deselect");

    // random mix
    for (int n = 0; n < 2000; n++) begin
      seg_done = 4'($urandom);
      for (int i = 0; i < 4; i++) seg_code[4*i +: 4] = pick_code(int'($urandom % 6));
      page_done = ($urandom % 5) == 0;
      reset_cmd = ($urandom % 23) == 0;
      cs = ($urandom % 17) != 0;
      rx_valid = ($urandom % 3) == 0;
      rx_byte = (($urandom % 2) == 0) ? 8'h7C : 8'($urandom);
      step("R2 R3 R6 R7 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule